// File: doc/BRIEF.md
# Return Address Stack Predictor

This block is a small hardware stack in a 64-bit fetch unit that guesses where a subroutine return will go. When decode sees a call, the block computes the return point: the call's PC plus 8, which is the address just past the delay slot. It pushes that value onto a circular stack. When decode sees a return, in either its normal or its leaf form, the block pops the top entry and presents it one clock later as the predicted fetch target.

A call whose target works out to exactly its own PC plus 8 is not a subroutine call. Code uses this form to read the program counter, so the block leaves the stack untouched for it. When the 32-bit address-mask mode is on, the upper half of the return address is cleared before the address is stored. The same masking is applied to both sides of the PC-read comparison.

The stack only predicts. It never writes architectural state, and it repairs nothing after a misprediction apart from a single flush input that empties it.

Top module: `ras_predictor`

## Requirements
- R1: A call whose target is not PC+8 pushes PC+8. A later return with nothing pushed in between gives `pred_valid`=1 and `pred_target`=that address one clock after the return strobe.
- R2: A call whose target (PC plus the sign-extended byte displacement) equals PC+8 pushes nothing. A return after it predicts the entry that was on top before it, or gives `pred_valid`=0 if the stack was empty.
- R3: Predictions come out in last-in, first-out order across nested calls.
- R4: When `addr_mask`=1, bits 63:32 of the pushed address are zero. The PC-read test then compares the two masked values, so a displacement of 0x1_0000_0008 counts as a PC read under masking and as a normal call without it.
- R5: `pred_valid` is high only in the cycle that follows a return strobe that found the stack non-empty. `pred_target` keeps its last value when no prediction is made.
- R6: A return on an empty stack gives `pred_valid`=0 on the next clock and changes neither the pointer nor the occupancy. A later push and pop behave as they would on a fresh stack.
- R7: The stack holds 8 entries. A push onto a full stack overwrites the oldest entry without stalling. After 9 pushes, 8 returns give the last 8 addresses in reverse order, and a 9th return gives `pred_valid`=0.
- R8: When a call and a return arrive in the same cycle, the return is taken first. The prediction is the old top, the pushed address replaces the top entry, and the occupancy stays the same. On an empty stack the prediction is invalid and the call pushes normally.
- R9: `flush` empties the stack in one cycle and takes precedence over a call or a return in the same cycle. That cycle yields `pred_valid`=0, and a return that follows also yields `pred_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empty the stack |
| call_valid | input | 1 | Call decoded this cycle |
| call_pc | input | 64 | PC of the call instruction |
| call_disp | input | 40 | Signed byte displacement of the call |
| ret_valid | input | 1 | Return (normal or leaf) decoded this cycle |
| addr_mask | input | 1 | 32-bit address-mask mode |
| pred_valid | output | 1 | Registered: a prediction is present |
| pred_target | output | 64 | Registered predicted return address |

## Verification
A corrupted top pointer or occupancy count shows up at the ports on the very next return. The prediction comes out as the wrong address, or valid is missing or present when it should not be, one clock after the strobe. A wrap or overwrite fault stays hidden until the stack has been filled past its depth and drained, so the overflow scenario empties the stack completely to expose it. Faults in masking or in the PC-read test change the next predicted value or the occupancy, and so do the ordering faults between a same-cycle call and return or a flush. The matching directed tests observe each of these as the first prediction after the stimulus.

// File: rtl/ras_pkg.sv
package ras_pkg;
   localparam int LOW_HALF_W = 32;
   localparam int LINK_OFFSET = 8;

   typedef enum logic [2:0] {
      OP_IDLE  = 3'd0,
      OP_POP   = 3'd1,
      OP_PUSH  = 3'd2,
      OP_SWAP  = 3'd3,
      OP_FLUSH = 3'd4,
      OP_MISS  = 3'd5
   } stack_op_e;
endpackage

// File: rtl/ras_link_calc.sv
module ras_link_calc #(
   parameter int ADDR_W = 64,
   parameter int DISP_W = 40
) (
   input  logic [ADDR_W-1:0] pc,
   input  logic [DISP_W-1:0] disp,
   input  logic              addr_mask,
   output logic [ADDR_W-1:0] link_addr,
   output logic              is_pcread
);
   import ras_pkg::*;

   logic [ADDR_W-1:0] disp_ext;
   logic [ADDR_W-1:0] raw_target;
   logic [ADDR_W-1:0] raw_link;
   logic [ADDR_W-1:0] mtarget;
   logic [ADDR_W-1:0] mlink;

   generate
      if (DISP_W < ADDR_W) begin : g_sext
         assign disp_ext = {{(ADDR_W-DISP_W){disp[DISP_W-1]}}, disp};
      end else begin : g_full
         assign disp_ext = disp[ADDR_W-1:0];
      end
   endgenerate

   assign raw_target = pc + disp_ext;
   assign raw_link   = pc + ADDR_W'(LINK_OFFSET);

   generate
      if (ADDR_W > LOW_HALF_W) begin : g_mask
         assign mtarget = addr_mask ? {{(ADDR_W-LOW_HALF_W){1'b0}}, raw_target[LOW_HALF_W-1:0]} : raw_target;
         assign mlink   = addr_mask ? {{(ADDR_W-LOW_HALF_W){1'b0}}, raw_link[LOW_HALF_W-1:0]}   : raw_link;
      end else begin : g_nomask
         assign mtarget = raw_target;
         assign mlink   = raw_link;
      end
   endgenerate

   assign link_addr = mlink;
   assign is_pcread = (mtarget == mlink);
endmodule

// File: rtl/ras_ptr_ctrl.sv
module ras_ptr_ctrl #(
   parameter int DEPTH = 8,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             push_req,
   input  logic             pop_req,
   output ras_pkg::stack_op_e op,
   output logic             wr_en,
   output logic [PTR_W-1:0] wr_idx,
   output logic [PTR_W-1:0] top_idx,
   output logic [CNT_W-1:0] count,
   output logic             pop_ok
);
   import ras_pkg::*;

   logic [PTR_W-1:0] top_q;
   logic [CNT_W-1:0] cnt_q;
   logic             empty;
   logic             full;

   assign empty = (cnt_q == '0);
   assign full  = (cnt_q == CNT_W'(DEPTH));

   always_comb begin
      if (flush)                        op = OP_FLUSH;
      else if (pop_req && !empty && push_req) op = OP_SWAP;
      else if (pop_req && !empty)       op = OP_POP;
      else if (push_req)                op = OP_PUSH;
      else if (pop_req)                 op = OP_MISS;
      else                              op = OP_IDLE;
   end

   always_comb begin
      wr_en  = 1'b0;
      wr_idx = top_q;
      unique case (op)
         OP_SWAP: begin wr_en = 1'b1; wr_idx = top_q; end
         OP_PUSH: begin wr_en = 1'b1; wr_idx = top_q + PTR_W'(1); end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         top_q <= '0;
         cnt_q <= '0;
      end else begin
         unique case (op)
            OP_FLUSH: cnt_q <= '0;
            OP_POP: begin
               top_q <= top_q - PTR_W'(1);
               cnt_q <= cnt_q - CNT_W'(1);
            end
            OP_PUSH: begin
               top_q <= top_q + PTR_W'(1);
               if (!full) cnt_q <= cnt_q + CNT_W'(1);
            end
            default: ;
         endcase
      end
   end

   assign top_idx = top_q;
   assign count   = cnt_q;
   assign pop_ok  = (op == OP_POP) || (op == OP_SWAP);
endmodule

// File: rtl/ras_entry_store.sv
module ras_entry_store #(
   parameter int DEPTH  = 8,
   parameter int ADDR_W = 64,
   localparam int PTR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [PTR_W-1:0]  wr_idx,
   input  logic [ADDR_W-1:0] wr_data,
   input  logic [PTR_W-1:0]  rd_idx,
   output logic [ADDR_W-1:0] rd_data
);
   logic [ADDR_W-1:0] slot [DEPTH];

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_slot
         always_ff @(posedge clk) begin
            if (!rst_n)
               slot[i] <= '0;
            else if (wr_en && (wr_idx == PTR_W'(i)))
               slot[i] <= wr_data;
         end
      end
   endgenerate

   assign rd_data = slot[rd_idx];
endmodule

// File: rtl/ras_predictor.sv
module ras_predictor #(
   parameter int ADDR_W = 64,
   parameter int DISP_W = 40,
   parameter int DEPTH  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              call_valid,
   input  logic [ADDR_W-1:0] call_pc,
   input  logic [DISP_W-1:0] call_disp,
   input  logic              ret_valid,
   input  logic              addr_mask,
   output logic              pred_valid,
   output logic [ADDR_W-1:0] pred_target
);
   localparam int PTR_W = $clog2(DEPTH);
   localparam int CNT_W = $clog2(DEPTH + 1);

   initial begin
      assert (DEPTH >= 2 && (1 << PTR_W) == DEPTH)
         else $error("DEPTH must be a power of two of at least 2");
      assert (DISP_W >= 2 && DISP_W <= ADDR_W)
         else $error("DISP_W must lie between 2 and ADDR_W");
      assert (ADDR_W >= 8)
         else $error("ADDR_W too small");
   end

   logic [ADDR_W-1:0] link_addr;
   logic              link_is_pcread;
   logic              push_req;
   ras_pkg::stack_op_e op;
   logic              wr_en;
   logic [PTR_W-1:0]  wr_idx;
   logic [PTR_W-1:0]  top_idx;
   logic [CNT_W-1:0]  occ_count;
   logic              pop_ok;
   logic [ADDR_W-1:0] top_data;

   ras_link_calc #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_link (
      .pc(call_pc), .disp(call_disp), .addr_mask(addr_mask),
      .link_addr(link_addr), .is_pcread(link_is_pcread)
   );

   assign push_req = call_valid && !link_is_pcread;

   ras_ptr_ctrl #(.DEPTH(DEPTH)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .push_req(push_req), .pop_req(ret_valid),
      .op(op), .wr_en(wr_en), .wr_idx(wr_idx), .top_idx(top_idx),
      .count(occ_count), .pop_ok(pop_ok)
   );

   ras_entry_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_store (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_data(link_addr), .rd_idx(top_idx), .rd_data(top_data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pred_valid  <= 1'b0;
         pred_target <= '0;
      end else begin
         pred_valid <= pop_ok;
         if (pop_ok) pred_target <= top_data;
      end
   end
endmodule

// File: rtl/ras_predictor_chk.sv
module ras_predictor_chk #(
   parameter int DEPTH = 8,
   parameter int CNT_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             flush,
   input logic             call_valid,
   input logic             ret_valid,
   input logic             pcread,
   input logic [CNT_W-1:0] count,
   input logic             pred_valid
);
   // R5: a prediction only follows a return strobe
   assert_pred_after_ret_R5: assert property (@(posedge clk) disable iff (!rst_n)
      pred_valid |-> $past(ret_valid));

   // R7: occupancy never exceeds the depth
   assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(DEPTH));

   // R9: flush empties the stack in one cycle
   assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (count == '0));

   // R6: return on empty gives no prediction and leaves occupancy alone
   assert_empty_pop_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_valid && !call_valid && !flush && count == '0) |=> (!pred_valid && count == '0));

   // R2: a PC-read call on its own leaves the occupancy unchanged
   assert_pcread_no_push_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (call_valid && pcread && !ret_valid && !flush) |=> $stable(count));

   // R8: call and return together keep a non-empty occupancy unchanged
   assert_swap_keeps_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (call_valid && !pcread && ret_valid && !flush && count != '0) |=> $stable(count));
endmodule

bind ras_predictor ras_predictor_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .flush(flush), .call_valid(call_valid),
   .ret_valid(ret_valid), .pcread(link_is_pcread), .count(occ_count),
   .pred_valid(pred_valid)
);

// File: tb/ras_predictor_test.sv
module ras_predictor_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        flush = 1'b0;
   logic        call_valid = 1'b0;
   logic [63:0] call_pc = '0;
   logic [39:0] call_disp = '0;
   logic        ret_valid = 1'b0;
   logic        addr_mask = 1'b0;
   logic        pred_valid;
   logic [63:0] pred_target;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   ras_predictor uut (
      .clk(clk), .rst_n(rst_n), .flush(flush), .call_valid(call_valid),
      .call_pc(call_pc), .call_disp(call_disp), .ret_valid(ret_valid),
      .addr_mask(addr_mask), .pred_valid(pred_valid), .pred_target(pred_target)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // one clock: drive at negedge, sample 1 ns after the rising edge
   task automatic step(input bit cv, input logic [63:0] pc, input logic [39:0] disp,
                       input bit rv, input bit fl, input bit m);
      @(negedge clk);
      call_valid = cv; call_pc = pc; call_disp = disp;
      ret_valid = rv; flush = fl; addr_mask = m;
      @(posedge clk);
      #1;
      call_valid = 1'b0; ret_valid = 1'b0; flush = 1'b0; addr_mask = 1'b0;
   endtask

   task automatic push(input logic [63:0] pc);
      step(1'b1, pc, 40'h40, 1'b0, 1'b0, 1'b0);
   endtask

   task automatic pop_expect(input string req, input bit v, input logic [63:0] t);
      step(1'b0, '0, '0, 1'b1, 1'b0, 1'b0);
      check(req, {63'd0, pred_valid}, {63'd0, v});
      if (v) check(req, pred_target, t);
   endtask

   task automatic drain();
      step(1'b0, '0, '0, 1'b0, 1'b1, 1'b0);
   endtask

   task automatic t_reset();
      check("R5 reset valid", {63'd0, pred_valid}, 64'd0);
      check("R5 reset target", pred_target, 64'd0);
      pop_expect("R6 empty pop after reset", 1'b0, '0);
   endtask

   task automatic t_basic();
      push(64'h1000);
      pop_expect("R1 basic", 1'b1, 64'h1008);
      pop_expect("R1 empty after", 1'b0, '0);
   endtask

   task automatic t_pcread();
      push(64'h2000);
      step(1'b1, 64'h3000, 40'h8, 1'b0, 1'b0, 1'b0);
      pop_expect("R2 pcread skipped", 1'b1, 64'h2008);
      pop_expect("R2 nothing extra", 1'b0, '0);
   endtask

   task automatic t_lifo();
      push(64'hA000); push(64'hB000); push(64'hC000);
      pop_expect("R3 third", 1'b1, 64'hC008);
      pop_expect("R3 second", 1'b1, 64'hB008);
      pop_expect("R3 first", 1'b1, 64'hA008);
      pop_expect("R3 empty", 1'b0, '0);
   endtask

   task automatic t_mask();
      step(1'b1, 64'hFFFF_0000_1234_0000, 40'h20, 1'b0, 1'b0, 1'b1);
      pop_expect("R4 masked push", 1'b1, 64'h0000_0000_1234_0008);
      step(1'b1, 64'h100, 40'h01_0000_0008, 1'b0, 1'b0, 1'b1);
      pop_expect("R4 masked pcread", 1'b0, '0);
      step(1'b1, 64'h100, 40'h01_0000_0008, 1'b0, 1'b0, 1'b0);
      pop_expect("R4 unmasked call", 1'b1, 64'h108);
   endtask

   task automatic t_hold();
      push(64'h5000);
      pop_expect("R5 pred", 1'b1, 64'h5008);
      step(1'b0, '0, '0, 1'b0, 1'b0, 1'b0);
      check("R5 valid drops", {63'd0, pred_valid}, 64'd0);
      check("R5 target held", pred_target, 64'h5008);
   endtask

   task automatic t_empty_state();
      pop_expect("R6 empty pop", 1'b0, '0);
      pop_expect("R6 empty pop twice", 1'b0, '0);
      push(64'h6000);
      pop_expect("R6 push after empty", 1'b1, 64'h6008);
      pop_expect("R6 empty again", 1'b0, '0);
   endtask

   task automatic t_overflow();
      for (int i = 1; i <= 9; i++) push(64'(i) * 64'h100);
      for (int i = 9; i >= 2; i--)
         pop_expect("R7 overflow order", 1'b1, 64'(i) * 64'h100 + 64'h8);
      pop_expect("R7 oldest dropped", 1'b0, '0);
   endtask

   task automatic t_simul();
      push(64'hA100); push(64'hB100);
      step(1'b1, 64'hC100, 40'h40, 1'b1, 1'b0, 1'b0);
      check("R8 swap valid", {63'd0, pred_valid}, 64'd1);
      check("R8 swap old top", pred_target, 64'hB108);
      pop_expect("R8 replaced top", 1'b1, 64'hC108);
      pop_expect("R8 below kept", 1'b1, 64'hA108);
      pop_expect("R8 count kept", 1'b0, '0);
      step(1'b1, 64'hD100, 40'h40, 1'b1, 1'b0, 1'b0);
      check("R8 empty swap invalid", {63'd0, pred_valid}, 64'd0);
      pop_expect("R8 empty swap pushed", 1'b1, 64'hD108);
      pop_expect("R8 empty after", 1'b0, '0);
   endtask

   task automatic t_flush();
      push(64'h7000); push(64'h7100);
      drain();
      pop_expect("R9 flushed", 1'b0, '0);
      push(64'h7200);
      step(1'b1, 64'h7300, 40'h40, 1'b0, 1'b1, 1'b0);
      pop_expect("R9 flush beats call", 1'b0, '0);
      push(64'h7400);
      step(1'b0, '0, '0, 1'b1, 1'b1, 1'b0);
      check("R9 flush beats ret", {63'd0, pred_valid}, 64'd0);
      pop_expect("R9 empty after flush", 1'b0, '0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      t_reset();
      t_basic();
      t_pcread();
      t_lifo();
      t_mask();
      t_hold();
      t_empty_state();
      t_overflow();
      t_simul();
      t_flush();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule